// File: doc/BRIEF.md
# Synchronous Smart Card Contact Controller

This block runs the contact side of a smart card in synchronous mode under control of a small processor-written register file. Once software enables the card supply, the block waits for an activation trigger. Software chooses whether that trigger is the supply-good flag or the expiry of an external supply timer. A fixed settling delay follows, during which IO is driven low. IO is then released into reception mode.

Once the card is active, software gates the card clock on and off and drives the card reset line through a register bit. It also picks the transfer direction. Received bits are sampled on rising card-clock edges. Transmitted bits change on falling edges. Each transferred bit is counted against a programmable length, and a sticky interrupt is raised when that length is reached.

One ETU is a programmable number of base clock cycles. The card clock period equals one ETU, with each phase lasting half an ETU.

Top module: `sc_sync_ctrl`

## Requirements
- R1: With the ready-select bit (CTRL bit 1) at 1, activation starts on the base clock edge after `vcc_ok_i` is seen high while the supply is enabled. `tmr_done_i` has no effect in this mode.
- R2: With the ready-select bit at 0, activation starts on `tmr_done_i` instead. `vcc_ok_i` has no effect in this mode.
- R3: While the block waits for the trigger, and for `IO_DLY` base cycles after it, `io_oe_o` is 1 and `io_do_o` is 0. After that, in receive mode, `io_oe_o` drops to 0.
- R4: While the clock-off bit (CTRL bit 2) is 1 on an active card, `card_clk_o` is held at the clock-level bit (CTRL bit 3).
- R5: When the clock-off bit is cleared with the card clock low, the first rising edge of `card_clk_o` comes exactly max(ETU/2,1) base cycles after the write. The ETU value is held in register 1.
- R6: In receive mode (CTRL bit 5 = 0), `io_i` is sampled at each rising edge of the card clock and shifted in MSB-first. After a transfer of LEN bits, `rx_data_o[LEN-1:0]` holds them, with the first bit received in the highest of those positions.
- R7: In transmit mode (CTRL bit 5 = 1), `io_oe_o` is 1 and the value written to register 3 is driven MSB-first. `io_do_o` changes only on falling card-clock edges.
- R8: When the bit count reaches the length held in register 2, `irq_o` rises. Counting and shifting then stop. `irq_o` stays high until bit 0 is written as 1 to register 4.
- R9: Writing a new value to the direction bit, or writing register 2, restarts the bit count and clears the receive shift register.
- R10: `card_rst_o` equals the card-reset bit (CTRL bit 4), non-inverted, while the supply is enabled and the card is powered.
- R11: Clearing the supply-enable bit (CTRL bit 0) drives `card_rst_o` and `io_oe_o` low at once. Within one further cycle, `card_clk_o` goes low, `irq_o` is cleared and the bit count is cleared. All outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 CTRL, 1 ETU, 2 LEN, 3 TXD, 4 IRQ clear |
| wr_data_i | input | DW | Register write data |
| vcc_ok_i | input | 1 | Card supply good |
| tmr_done_i | input | 1 | Supply timer expired |
| io_i | input | 1 | Card IO input |
| card_clk_o | output | 1 | Card clock |
| card_rst_o | output | 1 | Card reset |
| io_oe_o | output | 1 | IO drive enable |
| io_do_o | output | 1 | IO drive data |
| rx_data_o | output | DW | Received bits |
| irq_o | output | 1 | Transfer-length interrupt |

## Verification
The bench holds the trigger that should not count high while the block waits in each ready-select mode. A design that looks at the wrong flag would release IO early. It counts base cycles from the clock-off write to the first rising card-clock edge, which catches a clock that starts at once or one cycle late. It toggles the direction bit partway through a receive. A counter that is not cleared by that toggle raises the interrupt several bits too soon. After each interrupt it keeps the card clock running with fresh IO values, and a design that kept counting or shifting would corrupt the received word.

// File: rtl/sc_sync_pkg.sv
package sc_sync_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_WAIT, ST_DLY, ST_ACT} act_st_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_ETU  = 3'd1;
  localparam logic [2:0] A_LEN  = 3'd2;
  localparam logic [2:0] A_TXD  = 3'd3;
  localparam logic [2:0] A_ICLR = 3'd4;

  localparam int B_PWR = 0;
  localparam int B_RDY = 1;
  localparam int B_OFF = 2;
  localparam int B_LVL = 3;
  localparam int B_RST = 4;
  localparam int B_TX  = 5;
  localparam int CTRL_W = 6;
endpackage

// File: rtl/sc_act_fsm.sv
module sc_act_fsm
  import sc_sync_pkg::*;
#(
  parameter int IO_DLY = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pwr_en_i,
  input  logic    rdy_sel_i,
  input  logic    vcc_ok_i,
  input  logic    tmr_done_i,
  output act_st_e st_o
);
  localparam int DW = (IO_DLY < 2) ? 1 : $clog2(IO_DLY);
  localparam logic [DW-1:0] LAST = DW'(IO_DLY - 1);

  act_st_e st_q;
  logic [DW-1:0] dly_q;
  logic trig;

  assign trig = rdy_sel_i ? vcc_ok_i : tmr_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      dly_q <= '0;
    end else if (!pwr_en_i) begin
      st_q  <= ST_OFF;
      dly_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF:  st_q <= ST_WAIT;
        ST_WAIT: if (trig) begin
          st_q  <= ST_DLY;
          dly_q <= '0;
        end
        ST_DLY:  if (dly_q == LAST) st_q <= ST_ACT;
                 else dly_q <= dly_q + 1'b1;
        default: st_q <= ST_ACT;
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/sc_clk_gen.sv
module sc_clk_gen #(
  parameter int EW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          live_i,   // powered and active
  input  logic          off_i,
  input  logic          lvl_i,
  input  logic [EW-1:0] etu_i,
  output logic          clk_o,
  output logic          rise_o,
  output logic          fall_o
);
  logic [EW-1:0] half, cnt_q;
  logic clk_q, run, wrap;

  assign half = ((etu_i >> 1) == '0) ? EW'(1) : (etu_i >> 1);
  assign run  = live_i && !off_i;
  assign wrap = run && (cnt_q == half - EW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      clk_q <= live_i && lvl_i;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o  = clk_q;
  assign rise_o = wrap && !clk_q;
  assign fall_o = wrap && clk_q;
endmodule

// File: rtl/sc_shift_unit.sv
module sc_shift_unit #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,      // deactivation
  input  logic          restart_i,  // direction toggle or length write
  input  logic          tx_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          io_i,
  input  logic          len_wr_i,
  input  logic [DW-1:0] len_i,
  input  logic          txd_wr_i,
  input  logic [DW-1:0] txd_i,
  input  logic          iclr_i,
  output logic [DW-1:0] rx_o,
  output logic          io_do_o,
  output logic          irq_o
);
  logic [DW-1:0] len_q, cnt_q, rx_q, tx_q;
  logic irq_q, evt, busy;

  assign busy = cnt_q != len_q;
  assign evt  = busy && (tx_i ? fall_i : rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else if (len_wr_i) len_q <= len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= '0;
    else if (txd_wr_i) tx_q <= txd_i;
    else if (evt && tx_i) tx_q <= {tx_q[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
      irq_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (restart_i) begin
        cnt_q <= '0;
        rx_q  <= '0;
      end else if (evt) begin
        cnt_q <= cnt_q + 1'b1;
        if (!tx_i) rx_q <= {rx_q[DW-2:0], io_i};
      end
      if (evt && !restart_i && (cnt_q + DW'(1) == len_q)) irq_q <= 1'b1;
      else if (iclr_i) irq_q <= 1'b0;
    end
  end

  assign rx_o    = rx_q;
  assign io_do_o = tx_q[DW-1];
  assign irq_o   = irq_q;
endmodule

// File: rtl/sc_sync_ctrl.sv
module sc_sync_ctrl
  import sc_sync_pkg::*;
#(
  parameter int DW      = 8,
  parameter int IO_DLY  = 4,
  parameter int ETU_RST = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          vcc_ok_i,
  input  logic          tmr_done_i,
  input  logic          io_i,
  output logic          card_clk_o,
  output logic          card_rst_o,
  output logic          io_oe_o,
  output logic          io_do_o,
  output logic [DW-1:0] rx_data_o,
  output logic          irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0] etu_q;
  logic wr_ctrl, wr_etu, wr_len, wr_txd, wr_iclr;
  logic pwr_en, rdy_sel, clk_off, clk_lvl, tx_mode, mode_tog;
  logic live, rise, fall, sh_do;
  act_st_e act_st;

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_etu  = wr_en_i && (wr_addr_i == A_ETU);
  assign wr_len  = wr_en_i && (wr_addr_i == A_LEN);
  assign wr_txd  = wr_en_i && (wr_addr_i == A_TXD);
  assign wr_iclr = wr_en_i && (wr_addr_i == A_ICLR) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      etu_q  <= DW'(ETU_RST);
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data_i[CTRL_W-1:0];
      if (wr_etu)  etu_q  <= wr_data_i;
    end
  end

  assign pwr_en   = ctrl_q[B_PWR];
  assign rdy_sel  = ctrl_q[B_RDY];
  assign clk_off  = ctrl_q[B_OFF];
  assign clk_lvl  = ctrl_q[B_LVL];
  assign tx_mode  = ctrl_q[B_TX];
  assign mode_tog = wr_ctrl && (wr_data_i[B_TX] != tx_mode);
  assign live     = pwr_en && (act_st == ST_ACT);

  sc_act_fsm #(.IO_DLY(IO_DLY)) u_fsm (
    .clk_i, .rst_ni,
    .pwr_en_i  (pwr_en),
    .rdy_sel_i (rdy_sel),
    .vcc_ok_i,
    .tmr_done_i,
    .st_o      (act_st)
  );

  sc_clk_gen #(.EW(DW)) u_clk (
    .clk_i, .rst_ni,
    .live_i (live),
    .off_i  (clk_off),
    .lvl_i  (clk_lvl),
    .etu_i  (etu_q),
    .clk_o  (card_clk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  sc_shift_unit #(.DW(DW)) u_shift (
    .clk_i, .rst_ni,
    .clr_i     (!pwr_en),
    .restart_i (mode_tog || wr_len),
    .tx_i      (tx_mode),
    .rise_i    (rise),
    .fall_i    (fall),
    .io_i,
    .len_wr_i  (wr_len),
    .len_i     (wr_data_i),
    .txd_wr_i  (wr_txd),
    .txd_i     (wr_data_i),
    .iclr_i    (wr_iclr),
    .rx_o      (rx_data_o),
    .io_do_o   (sh_do),
    .irq_o
  );

  assign card_rst_o = pwr_en && (act_st != ST_OFF) && ctrl_q[B_RST];
  assign io_oe_o    = pwr_en && ((act_st == ST_WAIT) || (act_st == ST_DLY) || live && tx_mode);
  assign io_do_o    = live && tx_mode && sh_do;
endmodule

// File: rtl/sc_sync_ctrl_chk.sv
module sc_sync_ctrl_chk
  import sc_sync_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic       wr_d0,
  input logic       vcc_ok_i,
  input logic       tmr_done_i,
  input logic       card_clk_o,
  input logic       card_rst_o,
  input logic       io_oe_o,
  input logic       io_do_o,
  input logic       irq_o,
  input act_st_e    act_st,
  input logic       pwr_en,
  input logic       rdy_sel,
  input logic       clk_off,
  input logic       clk_lvl
);
  assert_vcc_trigger_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_st == ST_WAIT && rdy_sel && !vcc_ok_i) |=> act_st != ST_DLY);

  assert_tmr_trigger_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_st == ST_WAIT && !rdy_sel && !tmr_done_i) |=> act_st != ST_DLY);

  assert_clk_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(act_st == ST_ACT && pwr_en && clk_off) |-> card_clk_o == $past(clk_lvl));

  assert_tx_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o && $past(io_oe_o) && act_st == ST_ACT && $past(act_st) == ST_ACT
     && !$past(wr_en_i) && io_do_o != $past(io_do_o)) |-> $fell(card_clk_o));

  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && pwr_en && !(wr_en_i && wr_addr_i == A_ICLR && wr_d0)) |=> irq_o);

  assert_rst_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_st == ST_OFF |-> !card_rst_o);

  assert_deact_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en |-> !card_rst_o && !io_oe_o);
endmodule

bind sc_sync_ctrl sc_sync_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_d0      (wr_data_i[0]),
  .vcc_ok_i   (vcc_ok_i),
  .tmr_done_i (tmr_done_i),
  .card_clk_o (card_clk_o),
  .card_rst_o (card_rst_o),
  .io_oe_o    (io_oe_o),
  .io_do_o    (io_do_o),
  .irq_o      (irq_o),
  .act_st     (act_st),
  .pwr_en     (pwr_en),
  .rdy_sel    (rdy_sel),
  .clk_off    (clk_off),
  .clk_lvl    (clk_lvl)
);

// File: tb/sc_sync_ctrl_bench.sv
`timescale 1ns/1ps
module sc_sync_ctrl_bench;
  localparam int DW = 8;
  // ctrl bits: 0 pwr, 1 rdy, 2 off, 3 lvl, 4 rst, 5 tx
  localparam logic [7:0] C_PWR = 8'h01, C_RDY = 8'h02, C_OFF = 8'h04,
                         C_LVL = 8'h08, C_RST = 8'h10, C_TX = 8'h20;
  // {etu, len, pattern}
  localparam logic [23:0] VEC [0:5] = '{
    {8'd10, 8'd8, 8'hA5}, {8'd4, 8'd8, 8'h3C}, {8'd2, 8'd5, 8'h13},
    {8'd7, 8'd1, 8'h01},  {8'd3, 8'd8, 8'hFF}, {8'd6, 8'd3, 8'h05}};

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic vcc_ok = 0, tmr_done = 0, io_in = 0;
  logic card_clk, card_rst, io_oe, io_do, irq;
  logic [DW-1:0] rx_data;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sc_sync_ctrl u_sc_sync_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .vcc_ok_i(vcc_ok), .tmr_done_i(tmr_done), .io_i(io_in),
    .card_clk_o(card_clk), .card_rst_o(card_rst), .io_oe_o(io_oe),
    .io_do_o(io_do), .rx_data_o(rx_data), .irq_o(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung act=%0d exp=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // receive n bits, first bit = pat[n-1]; flags irq seen before last bit
  task automatic rx_bits(input logic [7:0] pat, input int n, output bit early);
    early = 0;
    for (int i = n - 1; i >= 0; i--) begin
      while (card_clk) tick();
      io_in = pat[i];
      while (!card_clk) tick();
      if (i > 0 && irq) early = 1;
    end
  endtask

  initial begin
    bit early;
    logic [7:0] got, exp_rx, mask, held;
    tick(3);
    // reset state, R11
    chk(!card_clk && !card_rst && !io_oe && !irq && rx_data == 0, "R11 reset",
        {card_clk, card_rst, io_oe, irq}, 0);
    rst_n = 1;
    tick(2);

    // R2: timer trigger, supply-good ignored
    wr(3'd0, C_PWR | C_OFF);
    tick(2);
    vcc_ok = 1;
    tick(10);
    chk(io_oe && !io_do, "R2 vcc ignored", {io_oe, io_do}, 2);
    tmr_done = 1;
    tick(4);
    chk(io_oe && !io_do, "R3 delay drives low", {io_oe, io_do}, 2);
    tick(1);
    chk(!io_oe, "R3 release", io_oe, 0);

    // R1: supply-good trigger, timer ignored
    wr(3'd0, 8'h00);
    tick(2);
    vcc_ok = 0;
    wr(3'd0, C_PWR | C_RDY | C_OFF);
    tick(10);
    chk(io_oe, "R1 tmr ignored", io_oe, 1);
    vcc_ok = 1;
    tick(5);
    chk(!io_oe, "R1 vcc trigger", io_oe, 0);

    // R4: clock held at level while off
    wr(3'd0, C_PWR | C_RDY | C_OFF | C_LVL);
    tick(2);
    chk(card_clk, "R4 level high", card_clk, 1);
    wr(3'd0, C_PWR | C_RDY | C_OFF);
    tick(2);
    chk(!card_clk, "R4 level low", card_clk, 0);

    // R10: reset passthrough
    wr(3'd0, C_PWR | C_RDY | C_OFF | C_RST);
    chk(card_rst, "R10 rst high", card_rst, 1);
    wr(3'd0, C_PWR | C_RDY | C_OFF);
    chk(!card_rst, "R10 rst low", card_rst, 0);

    // R5: half-ETU start delay
    wr(3'd1, 8'd10);
    wr(3'd0, C_PWR | C_RDY);
    held = 0;
    for (int i = 0; i < 4; i++) begin tick(); if (card_clk) held = 1; end
    chk(!held, "R5 early edge", held, 0);
    tick();
    chk(card_clk, "R5 first rise", card_clk, 1);
    wr(3'd0, C_PWR | C_RDY | C_OFF);

    // R6 / R8: receive vectors
    foreach (VEC[v]) begin
      wr(3'd0, C_PWR | C_RDY | C_OFF);
      wr(3'd1, VEC[v][23:16]);
      wr(3'd2, VEC[v][15:8]);
      wr(3'd4, 8'h01);
      io_in = 0;
      wr(3'd0, C_PWR | C_RDY);
      rx_bits(VEC[v][7:0], int'(VEC[v][15:8]), early);
      mask = 8'((9'd1 << VEC[v][15:8]) - 9'd1);
      exp_rx = VEC[v][7:0] & mask;
      chk(!early, "R8 irq early", early, 0);
      chk(irq, "R8 irq at len", irq, 1);
      chk(rx_data == exp_rx, "R6 rx data", rx_data, exp_rx);
      held = rx_data;
      rx_bits(~VEC[v][7:0], 2, early);
      chk(rx_data == held && irq, "R8 count stops", rx_data, held);
    end
    wr(3'd0, C_PWR | C_RDY | C_OFF);
    tick(3);
    chk(irq, "R8 sticky", irq, 1);
    wr(3'd4, 8'h01);
    tick();
    chk(!irq, "R8 clear", irq, 0);

    // R9: direction toggle restarts count
    wr(3'd1, 8'd4);
    wr(3'd2, 8'd8);
    wr(3'd0, C_PWR | C_RDY);
    rx_bits(8'hFF, 3, early);
    wr(3'd0, C_PWR | C_RDY | C_OFF);
    wr(3'd0, C_PWR | C_RDY | C_OFF | C_TX);
    wr(3'd0, C_PWR | C_RDY | C_OFF);
    wr(3'd0, C_PWR | C_RDY);
    rx_bits(8'h5A, 8, early);
    chk(!early, "R9 count restarted", early, 0);
    chk(irq && rx_data == 8'h5A, "R9 rx after toggle", rx_data, 8'h5A);

    // R7: transmit
    wr(3'd0, C_PWR | C_RDY | C_OFF | C_TX);
    wr(3'd3, 8'hC6);
    wr(3'd2, 8'd8);
    wr(3'd4, 8'h01);
    chk(io_oe && io_do, "R7 first bit", {io_oe, io_do}, 3);
    wr(3'd0, C_PWR | C_RDY | C_TX);
    got = 0; early = 0;
    for (int i = 0; i < 8; i++) begin
      while (card_clk) tick();
      while (!card_clk) tick();
      got = {got[6:0], io_do};
      if (irq) early = 1;
    end
    while (card_clk) tick();
    chk(got == 8'hC6, "R7 tx data", got, 8'hC6);
    chk(!early && irq, "R8 tx irq", {early, irq}, 1);

    // R11: deactivation
    wr(3'd0, C_PWR | C_RDY | C_TX | C_RST);
    wr(3'd0, 8'h00);
    chk(!card_rst && !io_oe, "R11 immediate", {card_rst, io_oe}, 0);
    tick();
    chk(!card_clk && !irq && !io_do, "R11 deactivated", {card_clk, irq, io_do}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule